// File: doc/BRIEF.md
# Priority Deflection Permutation Network

This block is the routing stage of a bufferless mesh router with four network inputs and four network outputs. In one cycle it places every valid incoming flit on some output, so that no flit needs a buffer. Each flit arrives with a preferred output that was computed upstream. It also carries a golden flag and a sequence number, which together keep the network free of livelock. The stage is built from four two-input steering cells in two ranks. Each cell picks a winner by priority and sends it toward its preferred side, and the other flit takes the cell's remaining side. The two ranks make their choices independently, so a flit can lose its preferred output in either rank.

Priority has three levels. Golden flits come first, and two golden flits are ordered by sequence number. Next comes a single silver flit, which the stage itself picks at random among the valid inputs each cycle. Ordinary flits come last. Ties between ordinary flits are broken by a free-running 16-bit LFSR, and the same LFSR drives the silver pick. Because the silver flit beats every ordinary flit in both ranks, at least one flit reaches its preferred output whenever no golden flit is present. Each output also reports whether its flit was deflected, so that downstream logic can act on it.

The datapath is combinational from input ports to output ports. The LFSR is the only state.

Top module: `defl_permuter`

## Requirements
- R1: Every valid input flit appears on exactly one output, with its preferred output, golden flag, sequence number and data unchanged. The number of valid outputs equals the number of valid inputs.
- R2: The preferred output is a 2-bit index, 0 to 3. The first rank pairs inputs {0,1} and {2,3}, and steers on preferred-output bit 1: a value of 0 goes toward outputs 0/1. The second rank steers on bit 0. A lone flit, or a set of flits that do not contend, reaches its preferred outputs with no deflection.
- R3: A golden flit beats any non-golden flit in every cell. When only one golden flit is valid, it is never deflected.
- R4: When two golden flits contend in a cell, the one with the lower sequence number wins.
- R5: Each cycle with at least one valid input, exactly one valid flit is marked silver on `out_silver`. A silver flit beats any ordinary flit. With no golden flit present, the silver flit is not deflected, so at least one output flit is undeflected.
- R6: A tie between two ordinary flits is decided by a bit of a free-running 16-bit LFSR. Under repeated identical contention, each contender wins in some cycles.
- R7: `out_defl[o]` is 1 exactly when output o carries a valid flit whose preferred output is not o. Empty outputs read 0 on every output field.
- R8: Reset loads a fixed nonzero seed into the LFSR. The LFSR never reaches zero, and identical traffic after two resets resolves ties identically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the tie-break LFSR |
| rst_n | input | 1 | Asynchronous active-low reset, loads the LFSR seed |
| in_valid | input | 4 | Flit present on each input |
| in_pref | input | 8 | Preferred output index, 2 bits per input |
| in_golden | input | 4 | Golden flag per input |
| in_seq | input | 4*SEQ_W | Sequence number per input |
| in_data | input | 4*DATA_W | Payload per input |
| out_valid | output | 4 | Flit present on each output |
| out_pref | output | 8 | Preferred output of the flit on each output |
| out_golden | output | 4 | Golden flag of the flit on each output |
| out_silver | output | 4 | Flit on this output was this cycle's silver pick |
| out_seq | output | 4*SEQ_W | Sequence number of the flit on each output |
| out_data | output | 4*DATA_W | Payload of the flit on each output |
| out_defl | output | 4 | Flit on this output is not at its preferred output |

## Verification
The datapath has no state, so a wrong steering or priority decision shows on the outputs in the same cycle the inputs are applied. It shows up as a lost or duplicated payload, a flit on the wrong output, or a wrong deflection flag. A broken LFSR or silver pick shows only over many cycles, so the bench repeats the same contention pattern. It checks that both contenders win at some point. It also uses a pattern where two uncoordinated ranks could deflect all four flits, and checks that the silver flit always stays undeflected. Replaying identical traffic after two resets exposes a seed that is not loaded.

// File: rtl/defl_permuter.sv
module defl_permuter #(
  parameter int SEQ_W = 4,
  parameter int DATA_W = 16,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          in_valid,
  input  logic [7:0]          in_pref,
  input  logic [3:0]          in_golden,
  input  logic [4*SEQ_W-1:0]  in_seq,
  input  logic [4*DATA_W-1:0] in_data,
  output logic [3:0]          out_valid,
  output logic [7:0]          out_pref,
  output logic [3:0]          out_golden,
  output logic [3:0]          out_silver,
  output logic [4*SEQ_W-1:0]  out_seq,
  output logic [4*DATA_W-1:0] out_data,
  output logic [3:0]          out_defl
);

  typedef struct packed {
    logic              v;
    logic [1:0]        pref;
    logic              g;
    logic              s;
    logic [SEQ_W-1:0]  seq;
    logic [DATA_W-1:0] d;
  } flit_t;

  typedef struct packed {
    flit_t hi;
    flit_t lo;
  } pair_t;

  logic [15:0] lfsr;
  logic [3:0]  silver;
  flit_t       fin [4];
  flit_t       fo  [4];
  pair_t       x0, x1, y0, y1;

  function automatic pair_t steer(flit_t a, flit_t b, logic bsel, logic coin);
    logic  a_first;
    flit_t w, l;
    pair_t r;
    if (!b.v)            a_first = 1'b1;
    else if (!a.v)       a_first = 1'b0;
    else if (a.g != b.g) a_first = a.g;
    else if (a.g)        a_first = (a.seq <= b.seq);
    else if (a.s != b.s) a_first = a.s;
    else                 a_first = coin;
    w = a_first ? a : b;
    l = a_first ? b : a;
    if (w.pref[bsel]) begin
      r.hi = w;
      r.lo = l;
    end else begin
      r.hi = l;
      r.lo = w;
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lfsr <= SEED;
    else        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  always_comb begin
    logic       found;
    logic [1:0] j;
    silver = '0;
    found  = 1'b0;
    for (int i = 0; i < 4; i++) begin
      j = lfsr[1:0] + 2'(i);
      if (!found && in_valid[j]) begin
        silver[j] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  always_comb
    for (int i = 0; i < 4; i++) begin
      fin[i] = '0;
      if (in_valid[i]) begin
        fin[i].v    = 1'b1;
        fin[i].pref = in_pref[2*i +: 2];
        fin[i].g    = in_golden[i];
        fin[i].s    = silver[i];
        fin[i].seq  = in_seq[SEQ_W*i +: SEQ_W];
        fin[i].d    = in_data[DATA_W*i +: DATA_W];
      end
    end

  assign x0 = steer(fin[0], fin[1], 1'b1, lfsr[2]);
  assign x1 = steer(fin[2], fin[3], 1'b1, lfsr[3]);
  assign y0 = steer(x0.lo, x1.lo, 1'b0, lfsr[4]);
  assign y1 = steer(x0.hi, x1.hi, 1'b0, lfsr[5]);

  assign fo[0] = y0.lo;
  assign fo[1] = y0.hi;
  assign fo[2] = y1.lo;
  assign fo[3] = y1.hi;

  always_comb
    for (int o = 0; o < 4; o++) begin
      out_valid[o]                 = fo[o].v;
      out_pref[2*o +: 2]           = fo[o].pref;
      out_golden[o]                = fo[o].g;
      out_silver[o]                = fo[o].s;
      out_seq[SEQ_W*o +: SEQ_W]    = fo[o].seq;
      out_data[DATA_W*o +: DATA_W] = fo[o].d;
      out_defl[o]                  = fo[o].v && (fo[o].pref != 2'(o));
    end

endmodule

module defl_permuter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  in_valid,
  input logic [3:0]  in_golden,
  input logic [3:0]  out_valid,
  input logic [3:0]  out_silver,
  input logic [3:0]  out_golden,
  input logic [3:0]  out_defl,
  input logic [15:0] lfsr
);

  a_r1_count_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_valid) == $countones(in_valid));

  a_r2_lone_flit_straight: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_valid) == 1 |-> out_defl == 4'b0000);

  a_r3_golden_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_valid & in_golden) == 1 |-> (out_defl & out_golden) == 4'b0000);

  a_r5_one_silver: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_valid) |-> $countones(out_silver & out_valid) == 1);

  a_r5_silver_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((|in_valid) && (in_valid & in_golden) == 4'b0000) |-> (out_silver & out_defl) == 4'b0000);

  a_r8_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != 16'h0000);

endmodule

bind defl_permuter defl_permuter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_golden(in_golden),
  .out_valid(out_valid), .out_silver(out_silver), .out_golden(out_golden),
  .out_defl(out_defl), .lfsr(lfsr)
);

// File: tb/test_defl_permuter.sv
module test_defl_permuter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  in_valid = '0;
  logic [7:0]  in_pref = '0;
  logic [3:0]  in_golden = '0;
  logic [15:0] in_seq = '0;
  logic [63:0] in_data = '0;
  logic [3:0]  out_valid, out_golden, out_silver, out_defl;
  logic [7:0]  out_pref;
  logic [15:0] out_seq;
  logic [63:0] out_data;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  defl_permuter #(.SEQ_W(4), .DATA_W(16)) i_defl_permuter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pref(in_pref),
    .in_golden(in_golden), .in_seq(in_seq), .in_data(in_data),
    .out_valid(out_valid), .out_pref(out_pref), .out_golden(out_golden),
    .out_silver(out_silver), .out_seq(out_seq), .out_data(out_data),
    .out_defl(out_defl)
  );

  function automatic logic [15:0] tag(input int i);
    return 16'hA0A0 + 16'(i);
  endfunction

  function automatic int where(input int i);
    int hit = -1;
    int cnt = 0;
    for (int o = 0; o < 4; o++)
      if (out_valid[o] && out_data[16*o +: 16] == tag(i)) begin
        hit = o;
        cnt++;
      end
    return (cnt > 1) ? -2 : hit;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    in_valid = '0; in_pref = '0; in_golden = '0; in_seq = '0; in_data = '0;
  endtask

  task automatic put(input int i, input int p, input logic g, input int sq);
    in_valid[i]        = 1'b1;
    in_pref[2*i +: 2]  = 2'(p);
    in_golden[i]       = g;
    in_seq[4*i +: 4]   = 4'(sq);
    in_data[16*i +: 16] = tag(i);
  endtask

  task automatic t_reset();
    clear_in();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R8", "empty valid", int'(out_valid), 0);
    chk("R7", "empty flags", int'(out_defl), 0);
    chk("R7", "empty data zero", int'(out_data == '0), 1);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_no_conflict();
    @(negedge clk);
    clear_in();
    put(0, 0, 0, 0); put(1, 2, 0, 0); put(2, 1, 0, 0); put(3, 3, 0, 0);
    #1;
    chk("R2", "in0 position", where(0), 0);
    chk("R2", "in1 position", where(1), 2);
    chk("R2", "in2 position", where(2), 1);
    chk("R2", "in3 position", where(3), 3);
    chk("R7", "no deflection", int'(out_defl), 0);
    chk("R1", "all valid", int'(out_valid), 15);
  endtask

  task automatic t_lone();
    for (int i = 0; i < 4; i++)
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        clear_in();
        put(i, p, 0, i + p);
        #1;
        chk("R2", "lone flit position", where(i), p);
        chk("R7", "lone flit flags", int'(out_defl), 0);
        chk("R1", "lone flit seq kept", int'(out_seq[4*p +: 4]), (i + p) % 16);
      end
  endtask

  task automatic t_golden();
    @(negedge clk);
    clear_in();
    put(0, 0, 1, 0); put(1, 0, 0, 0);
    #1;
    chk("R3", "golden first rank", where(0), 0);
    chk("R3", "loser position", where(1), 2);
    chk("R7", "loser flagged", int'(out_defl), 4'b0100);
    chk("R1", "golden flag kept", int'(out_golden), 4'b0001);
    @(negedge clk);
    clear_in();
    put(0, 3, 1, 0); put(2, 3, 0, 0);
    #1;
    chk("R3", "golden second rank", where(0), 3);
    chk("R3", "ordinary loser", where(2), 2);
    chk("R7", "second rank flag", int'(out_defl), 4'b0100);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      clear_in();
      put(0, 2, 0, 0); put(1, 2, 1, 0); put(2, 2, 0, 0); put(3, 2, 0, 0);
      #1;
      chk("R3", "golden under full load", where(1), 2);
      chk("R3", "golden not deflected", int'(out_defl[2]), 0);
    end
  endtask

  task automatic t_golden_tie();
    @(negedge clk);
    clear_in();
    put(0, 1, 1, 5); put(1, 1, 1, 2);
    #1;
    chk("R4", "lower seq wins", where(1), 1);
    chk("R4", "higher seq deflected", where(0), 3);
    @(negedge clk);
    clear_in();
    put(0, 1, 1, 1); put(1, 1, 1, 6);
    #1;
    chk("R4", "lower seq wins swapped", where(0), 1);
    chk("R4", "higher seq deflected swapped", where(1), 3);
    @(negedge clk);
    clear_in();
    put(0, 0, 1, 3); put(2, 0, 1, 7);
    #1;
    chk("R4", "second rank tie winner", where(0), 0);
    chk("R4", "second rank tie loser", where(2), 1);
    chk("R7", "second rank tie flags", int'(out_defl), 4'b0010);
  endtask

  task automatic t_silver();
    for (int c = 0; c < 32; c++) begin
      int ok = 1;
      @(negedge clk);
      clear_in();
      put(0, 0, 0, 0); put(1, 0, 0, 0); put(2, 2, 0, 0); put(3, 2, 0, 0);
      #1;
      for (int i = 0; i < 4; i++) if (where(i) < 0) ok = 0;
      chk("R1", "each flit once", ok, 1);
      chk("R5", "one silver", $countones(out_silver), 1);
      chk("R5", "silver undeflected", int'((out_silver & out_defl) == 4'b0000), 1);
      chk("R5", "some flit undeflected", int'(out_defl != 4'hF), 1);
    end
  endtask

  task automatic t_random();
    int w0 = 0;
    int w1 = 0;
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      clear_in();
      put(0, 0, 0, 0); put(1, 0, 0, 0);
      #1;
      chk("R1", "tie outputs", int'(out_valid), 4'b0101);
      if (where(0) == 0) w0++;
      if (where(1) == 0) w1++;
    end
    chk("R6", "input 0 wins sometimes", int'(w0 > 0), 1);
    chk("R6", "input 1 wins sometimes", int'(w1 > 0), 1);
  endtask

  task automatic run_ties(output int res[8]);
    clear_in();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      clear_in();
      put(0, 0, 0, 0); put(1, 0, 0, 0);
      #1;
      res[c] = where(0);
    end
  endtask

  task automatic t_reseed();
    int a[8];
    int b[8];
    int same = 1;
    run_ties(a);
    run_ties(b);
    for (int c = 0; c < 8; c++) if (a[c] != b[c]) same = 0;
    chk("R8", "seed replays ties", same, 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    t_reset();
    t_no_conflict();
    t_lone();
    t_golden();
    t_golden_tie();
    t_silver();
    t_random();
    t_reseed();
    finish_run();
  end

endmodule